// File: doc/BRIEF.md
# Dual-Depth Graphics Pixel Serializer

The serializer sits at the end of a color graphics pipeline. Once per character period it takes one video memory byte and plays it out as pixel indices, one per dot clock. A character period is eight dot clocks long. The byte rate and the character timing do not depend on the pixel depth.

Two depths share one shift register. In medium-resolution mode each pair of bits is one 2-bit pixel, and that pixel is held for two dots. In high-resolution mode each pair is split into two single-bit pixels, high bit first. A set bit becomes index 3 and a clear bit becomes index 0. When display-enable is low, or when no byte is being played out, the output shows the background index.

The sequencer is a two-state machine.
- `ST_IDLE` means no byte is active. It moves to `ST_RUN` on a load strobe.
- `ST_RUN` steps the dot phase from 0 to 7.
  - A load strobe in any phase restarts it at phase 0 with the new byte.
  - When phase 7 ends without a load, the machine returns to `ST_IDLE`.

Top module: `gfx_pixel_serializer`

## Requirements
- R1: While `rst` is high on a rising edge, the block clears its shift register, sets the dot phase to 0 and enters `ST_IDLE`. After reset, `pix_out` equals `bg_sel` until the next load.
- R2: A load starts a period of exactly eight dot clocks. The dot phase advances by one on each clock, from 0 to 7.
- R3: With `hires`=0, the pixel in dot p (0..7) is `data_in[7-2*(p/2) : 6-2*(p/2)]`. Bits [7:6] come first, and each value is held for two dots.
- R4: With `hires`=1, the pixel in dot p is 3 when `data_in[7-p]` is 1 and 0 when it is 0.
- R5: A load in dot 7 starts the next byte in the very next dot, with no gap.
- R6: When `disp_en` is 0, `pix_out` equals `bg_sel` in every dot.
- R7: If dot 7 passes with no load, the block enters `ST_IDLE`, and `pix_out` equals `bg_sel` until the next load.
- R8: A load in the middle of a period drops the rest of the old byte and starts the new byte at dot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst | input | 1 | Synchronous reset, active high |
| load | input | 1 | Character-rate strobe that captures `data_in` |
| data_in | input | 8 | Video memory byte |
| hires | input | 1 | 1 = one bit per pixel, 0 = two bits per pixel |
| disp_en | input | 1 | Display enable; low forces the background |
| bg_sel | input | 2 | Background / palette index |
| pix_out | output | 2 | Pixel index for the current dot |

## Verification
The hardest conditions to reach are the seam between bytes and an early reload. Both need the load strobe placed in a chosen dot relative to the running phase. The bench drives the strobe in lockstep with its own dot counter, so every one of the 256 byte values in each mode is followed directly by the next byte. It then places loads in dot 3 and stops loads after dot 7. This reaches the restart path and the return to `ST_IDLE` from known positions.

// File: rtl/gps_pkg.sv
package gps_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } ser_state_e;
endpackage

// File: rtl/gps_char_divider.sv
module gps_char_divider
    import gps_pkg::*;
#(
    parameter int PIX_PER_CHAR = 8
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            load,
    output logic [$clog2(PIX_PER_CHAR)-1:0] phase,
    output logic                            running
);
    localparam int PHASE_W = $clog2(PIX_PER_CHAR);
    localparam logic [PHASE_W-1:0] LAST_PHASE = PHASE_W'(PIX_PER_CHAR - 1);

    ser_state_e state, state_nxt;

    // next-state selection
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: if (load) state_nxt = ST_RUN;
            ST_RUN: begin
                if (load)                     state_nxt = ST_RUN;
                else if (phase == LAST_PHASE) state_nxt = ST_IDLE;
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nxt;
    end

    // dot phase counter
    always_ff @(posedge clk) begin
        if (rst || load)
            phase <= '0;
        else if (state == ST_RUN && phase != LAST_PHASE)
            phase <= phase + 1'b1;
        else
            phase <= '0;
    end

    // outputs
    always_comb begin
        running = (state == ST_RUN);
    end

    // R1: reset leaves the sequencer idle at phase 0
    a_r1_reset_idle: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (state == ST_IDLE && phase == '0));
    // R2: phase steps by one inside a period
    a_r2_phase_step: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN && !load && phase != LAST_PHASE) |=> (phase == $past(phase) + 1'b1));
    // R5 / R8: a load always restarts at dot 0 in run
    a_r8_load_restart: assert property (@(posedge clk) disable iff (rst)
        load |=> (state == ST_RUN && phase == '0));
    // R7: end of period without reload goes idle
    a_r7_end_idle: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN && phase == LAST_PHASE && !load) |=> (state == ST_IDLE));
endmodule

// File: rtl/gps_shifter.sv
module gps_shifter #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DATA_W-1:0] data_in,
    input  logic              advance,
    output logic [1:0]        pair
);
    logic [DATA_W-1:0] shreg;

    always_ff @(posedge clk) begin
        if (rst)
            shreg <= '0;
        else if (load)
            shreg <= data_in;
        else if (advance)
            shreg <= {shreg[DATA_W-3:0], 2'b00};
    end

    always_comb begin
        pair = shreg[DATA_W-1 -: 2];
    end

    // R3 / R4: a load captures the byte
    a_r3_capture: assert property (@(posedge clk) disable iff (rst)
        load |=> (shreg == $past(data_in)));
    // R3: the register shifts by one packet on an advance
    a_r3_packet_shift: assert property (@(posedge clk) disable iff (rst)
        (!load && advance) |=> (shreg == {$past(shreg[DATA_W-3:0]), 2'b00}));
    // R3: otherwise the register holds
    a_r3_hold: assert property (@(posedge clk) disable iff (rst)
        (!load && !advance) |=> $stable(shreg));
endmodule

// File: rtl/gps_pixel_mux.sv
module gps_pixel_mux (
    input  logic [1:0] pair,
    input  logic       odd_dot,
    input  logic       running,
    input  logic       hires,
    input  logic       disp_en,
    input  logic [1:0] bg_sel,
    output logic [1:0] pix
);
    logic bit_sel;

    always_comb begin
        bit_sel = odd_dot ? pair[0] : pair[1];
        if (!disp_en || !running)
            pix = bg_sel;
        else if (hires)
            pix = {bit_sel, bit_sel};
        else
            pix = pair;
    end
endmodule

// File: rtl/gfx_pixel_serializer.sv
module gfx_pixel_serializer #(
    parameter int PIX_PER_CHAR = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    load,
    input  logic [PIX_PER_CHAR-1:0] data_in,
    input  logic                    hires,
    input  logic                    disp_en,
    input  logic [1:0]              bg_sel,
    output logic [1:0]              pix_out
);
    localparam int PHASE_W = $clog2(PIX_PER_CHAR);

    logic [PHASE_W-1:0] phase;
    logic               running;
    logic [1:0]         pair;
    logic               advance;

    gps_char_divider #(.PIX_PER_CHAR(PIX_PER_CHAR)) u_div (
        .clk     (clk),
        .rst     (rst),
        .load    (load),
        .phase   (phase),
        .running (running)
    );

    always_comb begin
        advance = running && phase[0];
    end

    gps_shifter #(.DATA_W(PIX_PER_CHAR)) u_shift (
        .clk     (clk),
        .rst     (rst),
        .load    (load),
        .data_in (data_in),
        .advance (advance),
        .pair    (pair)
    );

    gps_pixel_mux u_mux (
        .pair    (pair),
        .odd_dot (phase[0]),
        .running (running),
        .hires   (hires),
        .disp_en (disp_en),
        .bg_sel  (bg_sel),
        .pix     (pix_out)
    );

    // R4: in 1bpp mode only indices 0 and 3 appear while displaying
    a_r4_two_levels: assert property (@(posedge clk) disable iff (rst)
        (hires && disp_en && running) |-> (pix_out == 2'b00 || pix_out == 2'b11));
endmodule

// File: tb/gfx_pixel_serializer_bench.sv
module gfx_pixel_serializer_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       load = 1'b0;
    logic [7:0] data_in = '0;
    logic       hires = 1'b0;
    logic       disp_en = 1'b1;
    logic [1:0] bg_sel = 2'd2;
    logic [1:0] pix_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    gfx_pixel_serializer u_gfx_pixel_serializer (
        .clk(clk), .rst(rst), .load(load), .data_in(data_in),
        .hires(hires), .disp_en(disp_en), .bg_sel(bg_sel), .pix_out(pix_out)
    );

    always #10 clk = ~clk;

    function automatic logic [1:0] exp_pix(input logic [7:0] d, input int p);
        if (!disp_en) return bg_sel;
        if (hires) return ((d >> (7 - p)) & 8'd1) != 0 ? 2'd3 : 2'd0;
        return 2'((d >> (6 - 2 * (p / 2))) & 8'd3);
    endfunction

    task automatic check(input string req, input logic [1:0] exp);
        checks++;
        if (pix_out !== exp) begin
            errors++;
            $display("FAIL %s: pix_out=%0d expected=%0d at %0t", req, pix_out, exp, $time);
        end
    endtask

    task automatic tick(input logic ld, input logic [7:0] d);
        @(negedge clk);
        load = ld;
        data_in = d;
        @(posedge clk);
        #5;
    endtask

    // play one byte; dots [0, ndots) checked; reload happens on the following tick
    task automatic play(input logic [7:0] d, input int ndots, input string tag0);
        tick(1'b1, d);
        check(tag0, exp_pix(d, 0));
        for (int p = 1; p < ndots; p++) begin
            tick(1'b0, 8'h00);
            if (p == 7) check("R2", exp_pix(d, p));
            else check(hires ? "R4" : "R3", exp_pix(d, p));
        end
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog: pix_out=%0d expected=finish", pix_out);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #5;
        check("R1", 2'd2);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #5;
        check("R1", 2'd2);

        // R3 / R5: medium-res, all bytes back to back
        bg_sel = 2'd1;
        hires = 1'b0;
        for (int b = 0; b < 256; b++) play(8'(b), 8, b == 0 ? "R3" : "R5");
        tick(1'b0, 8'h00);
        check("R7", 2'd1);
        tick(1'b0, 8'h00);
        check("R7", 2'd1);

        // R4 / R5: high-res, all bytes back to back
        hires = 1'b1;
        for (int b = 0; b < 256; b++) play(8'(255 - b), 8, b == 0 ? "R4" : "R5");
        tick(1'b0, 8'h00);
        check("R7", 2'd1);

        // R6: display disabled shows background for every bg value
        disp_en = 1'b0;
        for (int g = 0; g < 4; g++) begin
            bg_sel = 2'(g);
            hires = g[0];
            tick(1'b1, 8'hA5);
            check("R6", 2'(g));
            for (int p = 1; p < 8; p++) begin
                tick(1'b0, 8'h00);
                check("R6", 2'(g));
            end
        end
        disp_en = 1'b1;
        bg_sel = 2'd2;

        // R8: reload in dot 3 restarts at dot 0 with the new byte
        for (int m = 0; m < 2; m++) begin
            hires = m[0];
            play(8'h3C, 4, "R3");
            play(8'hC9, 8, "R8");
            tick(1'b0, 8'h00);
            check("R7", 2'd2);
        end

        // R1: reset in mid-byte returns to background
        hires = 1'b0;
        play(8'hFF, 3, "R3");
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #5;
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #5;
        check("R1", 2'd2);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule